// File: doc/BRIEF.md
# Distinguished-Point Chain Evaluator

This block sits beside a group of chain-stepping elements in a precomputation engine. After an element finishes a full period of step functions, it shifts its current point into the evaluator one bit per cycle, most significant bit first. With the first bit it also presents the number of periods its chain has run. The evaluator serves the elements one after another in a fixed rotating order. For each element it decides whether the chain continues, is stored, or is thrown away.

A point is distinguished when its top `DP_BITS` bits are all zero. A distinguished point reached inside the allowed window of periods ends the chain and stores it. The FIFO entry holds three fields: the chain's start point, the end point and the timer value captured when the chain was started. A chain that ends in any way, stored or discarded, is reloaded in the same cycle with the next value of an incrementing start-point generator. The current timer value is latched as the new chain's birth time. While a kept chain waits for a full FIFO, the evaluator stalls the serial input so that no result is lost.

Top module: `dp_chain_eval`

## Requirements
- R1: After reset `pt_ready_o` is 1, `fifo_wr_o` and `rld_valid_o` are 0, element i holds start point `SP_BASE+i` with birth time 0, and the generator's first value is `SP_BASE+N_ELEM`.
- R2: A point is taken in as `PT_W` accepted bits (`pt_valid_i` and `pt_ready_o` both high), most significant bit first. The period count is sampled together with the first bit only. In the cycle after the last bit, `pt_ready_o` is 0 and the decision outputs are valid.
- R3: A point counts as distinguished exactly when its `DP_BITS` most significant bits are all zero.
- R4: A distinguished point with period count k, where `K_MIN < k < K_MAX`, produces one FIFO write of `{start, end, birth}`. The start point occupies the top `PT_W` bits, the end point the next `PT_W` bits and the birth time the low `TS_W` bits.
- R5: A distinguished point with k <= `K_MIN`, or with k >= `K_MAX`, writes nothing and reloads the element.
- R6: A non-distinguished point with k >= `K_MAX` writes nothing and reloads the element.
- R7: A non-distinguished point with k < `K_MAX` writes nothing and does not reload. The element keeps its stored start point and birth time.
- R8: On a reload, `rld_point_o` carries the next generator value; successive reloads receive consecutive values. The element's birth time becomes the `timer_i` value of that cycle.
- R9: Elements are evaluated in the order 0, 1, ..., `N_ELEM-1`, 0, ..., and `rld_elem_o` names the element being evaluated.
- R10: A kept chain meeting `fifo_full_i` high holds the decision: no write, no reload, and `pt_ready_o` stays 0 until the FIFO has room, at which point the write and the reload go out together. Discards and continues do not wait for the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_valid_i | input | 1 | Serial point bit is valid |
| pt_bit_i | input | 1 | Serial point bit, MSB first |
| pt_ready_o | output | 1 | Evaluator accepts a serial bit |
| per_cnt_i | input | K_W | Period count of the chain, sampled with the first bit |
| timer_i | input | TS_W | Free-running timer |
| fifo_full_i | input | 1 | Output FIFO cannot accept a write |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 2*PT_W+TS_W | {start point, end point, birth time} |
| rld_valid_o | output | 1 | Reload the evaluated element |
| rld_elem_o | output | EI_W | Index of the element being reloaded |
| rld_point_o | output | PT_W | Fresh start point for the element |

## Verification
The FIFO write and the reload of the element fall in the same cycle whenever a chain is kept. This is the case where backpressure matters. The bench holds `fifo_full_i` high for several cycles during a keep decision and checks each stalled cycle: neither strobe goes out and the serial input stays blocked. Once the FIFO frees, both strobes are expected together with the correct start point, generator value and birth time. It also raises `fifo_full_i` during discard and continue decisions and expects them to proceed at once.

// File: rtl/dpe_pkg.sv
package dpe_pkg;
    typedef enum logic [1:0] {
        V_CONT  = 2'd0,
        V_KEEP  = 2'd1,
        V_EARLY = 2'd2,
        V_LONG  = 2'd3
    } verdict_e;

    typedef enum logic {
        PH_COLLECT = 1'b0,
        PH_DECIDE  = 1'b1
    } phase_e;
endpackage

// File: rtl/dpe_deser.sv
module dpe_deser #(
    parameter int PT_W = 64,
    parameter int K_W  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_i,
    input  logic            bit_i,
    input  logic [K_W-1:0]  k_i,
    output logic [PT_W-1:0] point_o,
    output logic [K_W-1:0]  k_o,
    output logic            last_o
);
    localparam int CNT_W = $clog2(PT_W);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(PT_W - 1);

    typedef struct packed {
        logic [PT_W-1:0]  pt;
        logic [K_W-1:0]   k;
        logic [CNT_W-1:0] cnt;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d   = sh_q;
        last_o = take_i && (sh_q.cnt == CNT_TOP);
        if (take_i) begin
            sh_d.pt = {sh_q.pt[PT_W-2:0], bit_i};
            if (sh_q.cnt == '0) begin
                sh_d.k = k_i;
            end
            sh_d.cnt = last_o ? '0 : sh_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign point_o = sh_q.pt;
    assign k_o     = sh_q.k;
endmodule

// File: rtl/dpe_judge.sv
module dpe_judge #(
    parameter int PT_W    = 64,
    parameter int K_W     = 8,
    parameter int DP_BITS = 5,
    parameter int K_MIN   = 8,
    parameter int K_MAX   = 64
) (
    input  logic [PT_W-1:0]   point_i,
    input  logic [K_W-1:0]    k_i,
    output dpe_pkg::verdict_e verdict_o
);
    import dpe_pkg::*;

    localparam logic [K_W-1:0] LO = K_W'(K_MIN);
    localparam logic [K_W-1:0] HI = K_W'(K_MAX);

    logic is_dp;

    always_comb begin
        is_dp = (point_i[PT_W-1 -: DP_BITS] == '0);
        if (is_dp) begin
            verdict_o = (k_i > LO && k_i < HI) ? V_KEEP : V_EARLY;
        end else begin
            verdict_o = (k_i >= HI) ? V_LONG : V_CONT;
        end
    end
endmodule

// File: rtl/dp_chain_eval.sv
module dp_chain_eval #(
    parameter int              N_ELEM  = 4,
    parameter int              PT_W    = 64,
    parameter int              TS_W    = 32,
    parameter int              K_W     = 8,
    parameter int              DP_BITS = 5,
    parameter int              K_MIN   = 8,
    parameter int              K_MAX   = 64,
    parameter logic [PT_W-1:0] SP_BASE = '0,
    localparam int             EI_W    = (N_ELEM > 1) ? $clog2(N_ELEM) : 1,
    localparam int             FD_W    = 2 * PT_W + TS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pt_valid_i,
    input  logic            pt_bit_i,
    output logic            pt_ready_o,
    input  logic [K_W-1:0]  per_cnt_i,
    input  logic [TS_W-1:0] timer_i,
    input  logic            fifo_full_i,
    output logic            fifo_wr_o,
    output logic [FD_W-1:0] fifo_data_o,
    output logic            rld_valid_o,
    output logic [EI_W-1:0] rld_elem_o,
    output logic [PT_W-1:0] rld_point_o
);
    import dpe_pkg::*;

    localparam logic [EI_W-1:0] IDX_TOP = EI_W'(N_ELEM - 1);

    typedef struct packed {
        phase_e                      ph;
        logic [EI_W-1:0]             idx;
        logic [PT_W-1:0]             gen;
        logic [N_ELEM-1:0][PT_W-1:0] sp;
        logic [N_ELEM-1:0][TS_W-1:0] birth;
    } st_t;

    function automatic st_t init_st();
        st_t s;
        s.ph  = PH_COLLECT;
        s.idx = '0;
        s.gen = SP_BASE + PT_W'(N_ELEM);
        for (int i = 0; i < N_ELEM; i++) begin
            s.sp[i]    = SP_BASE + PT_W'(i);
            s.birth[i] = '0;
        end
        return s;
    endfunction

    st_t st_d, st_q;

    logic            take;
    logic            last_bit;
    logic [PT_W-1:0] end_pt;
    logic [K_W-1:0]  end_k;
    verdict_e        verdict;
    logic            keep;
    logic            chain_end;
    logic            go;

    dpe_deser #(.PT_W(PT_W), .K_W(K_W)) deser_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (take),
        .bit_i   (pt_bit_i),
        .k_i     (per_cnt_i),
        .point_o (end_pt),
        .k_o     (end_k),
        .last_o  (last_bit)
    );

    dpe_judge #(
        .PT_W(PT_W), .K_W(K_W), .DP_BITS(DP_BITS), .K_MIN(K_MIN), .K_MAX(K_MAX)
    ) judge_i (
        .point_i   (end_pt),
        .k_i       (end_k),
        .verdict_o (verdict)
    );

    always_comb begin
        st_d        = st_q;
        pt_ready_o  = (st_q.ph == PH_COLLECT);
        take        = pt_valid_i && pt_ready_o;
        keep        = (verdict == V_KEEP);
        chain_end   = (verdict != V_CONT);
        go          = (st_q.ph == PH_DECIDE) && !(keep && fifo_full_i);
        fifo_wr_o   = go && keep;
        rld_valid_o = go && chain_end;
        rld_elem_o  = st_q.idx;
        rld_point_o = st_q.gen;
        fifo_data_o = {st_q.sp[st_q.idx], end_pt, st_q.birth[st_q.idx]};

        if (last_bit) begin
            st_d.ph = PH_DECIDE;
        end
        if (go) begin
            st_d.ph  = PH_COLLECT;
            st_d.idx = (st_q.idx == IDX_TOP) ? '0 : st_q.idx + 1'b1;
            if (chain_end) begin
                st_d.sp[st_q.idx]    = st_q.gen;
                st_d.birth[st_q.idx] = timer_i;
                st_d.gen             = st_q.gen + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= init_st();
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dp_chain_eval_chk.sv
module dp_chain_eval_chk #(
    parameter int              N_ELEM  = 4,
    parameter int              PT_W    = 64,
    parameter int              TS_W    = 32,
    parameter int              DP_BITS = 5,
    parameter logic [PT_W-1:0] SP_BASE = '0,
    localparam int             EI_W    = (N_ELEM > 1) ? $clog2(N_ELEM) : 1,
    localparam int             FD_W    = 2 * PT_W + TS_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pt_ready_o,
    input logic            fifo_full_i,
    input logic            fifo_wr_o,
    input logic [FD_W-1:0] fifo_data_o,
    input logic            rld_valid_o,
    input logic [EI_W-1:0] rld_elem_o,
    input logic [PT_W-1:0] rld_point_o
);
    logic [PT_W-1:0] exp_gen;
    logic [EI_W-1:0] exp_elem;
    logic            rdy_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_gen  <= SP_BASE + PT_W'(N_ELEM);
            exp_elem <= '0;
            rdy_prev <= 1'b1;
        end else begin
            rdy_prev <= pt_ready_o;
            if (rld_valid_o) begin
                exp_gen <= exp_gen + 1'b1;
            end
            if (pt_ready_o && !rdy_prev) begin
                exp_elem <= (exp_elem == EI_W'(N_ELEM - 1)) ? '0 : exp_elem + 1'b1;
            end
        end
    end

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_o |-> !fifo_full_i);

    p_write_with_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_o |-> rld_valid_o);

    p_kept_is_dp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_o |-> (fifo_data_o[TS_W+PT_W-1 -: DP_BITS] == '0));

    p_gen_consecutive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rld_valid_o |-> (rld_point_o == exp_gen));

    p_rotation_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rld_valid_o |-> (rld_elem_o == exp_elem));

    p_outputs_in_decide_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr_o || rld_valid_o) |-> !pt_ready_o);

    p_resume_after_go_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rld_valid_o |=> pt_ready_o);
endmodule

bind dp_chain_eval dp_chain_eval_chk #(
    .N_ELEM(N_ELEM), .PT_W(PT_W), .TS_W(TS_W), .DP_BITS(DP_BITS), .SP_BASE(SP_BASE)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pt_ready_o  (pt_ready_o),
    .fifo_full_i (fifo_full_i),
    .fifo_wr_o   (fifo_wr_o),
    .fifo_data_o (fifo_data_o),
    .rld_valid_o (rld_valid_o),
    .rld_elem_o  (rld_elem_o),
    .rld_point_o (rld_point_o)
);

// File: tb/dp_chain_eval_tb_top.sv
module dp_chain_eval_tb_top;
    localparam int N    = 4;
    localparam int PW   = 64;
    localparam int TW   = 32;
    localparam int KW   = 8;
    localparam int DB   = 5;
    localparam int KLO  = 8;
    localparam int KHI  = 64;
    localparam int EW   = 2;
    localparam int FW   = 2 * PW + TW;
    localparam logic [PW-1:0] BASE = 64'h0000_1000_0000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pt_valid = 1'b0;
    logic          pt_bit = 1'b0;
    logic          pt_ready;
    logic [KW-1:0] per_cnt = '0;
    logic [TW-1:0] tmr = '0;
    logic          fifo_full = 1'b0;
    logic          fifo_wr;
    logic [FW-1:0] fifo_data;
    logic          rld_valid;
    logic [EW-1:0] rld_elem;
    logic [PW-1:0] rld_point;

    int checks = 0;
    int errors = 0;

    logic [PW-1:0] m_sp [N];
    logic [TW-1:0] m_birth [N];
    logic [PW-1:0] m_gen;
    int            m_idx;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) tmr <= '0;
        else        tmr <= tmr + 1'b1;
    end

    dp_chain_eval #(
        .N_ELEM(N), .PT_W(PW), .TS_W(TW), .K_W(KW), .DP_BITS(DB),
        .K_MIN(KLO), .K_MAX(KHI), .SP_BASE(BASE)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pt_valid_i  (pt_valid),
        .pt_bit_i    (pt_bit),
        .pt_ready_o  (pt_ready),
        .per_cnt_i   (per_cnt),
        .timer_i     (tmr),
        .fifo_full_i (fifo_full),
        .fifo_wr_o   (fifo_wr),
        .fifo_data_o (fifo_data),
        .rld_valid_o (rld_valid),
        .rld_elem_o  (rld_elem),
        .rld_point_o (rld_point)
    );

    task automatic chk(input bit ok, input string req, input logic [FW-1:0] act,
                       input logic [FW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_dp(input logic [PW-1:0] p);
        return p[PW-1 -: DB] == '0;
    endfunction

    // one evaluation: shift the point in, optionally hold the FIFO full, check the decision
    task automatic run_eval(input logic [PW-1:0] p, input int k, input int stall,
                            input string tag);
        bit dp, keep, fin;
        dp   = exp_dp(p);
        keep = dp && k > KLO && k < KHI;
        fin  = keep || dp || (k >= KHI);
        chk(pt_ready === 1'b1, {tag, " R2 ready before bits"}, FW'(pt_ready), FW'(1));
        for (int b = PW - 1; b >= 0; b--) begin
            pt_valid = 1'b1;
            pt_bit   = p[b];
            per_cnt  = (b == PW - 1) ? KW'(k) : KW'($urandom);
            @(posedge clk);
            @(negedge clk);
        end
        pt_valid = 1'b0;
        per_cnt  = KW'($urandom);
        if (keep) begin
            for (int s = 0; s < stall; s++) begin
                fifo_full = 1'b1;
                #1;
                chk(fifo_wr === 1'b0 && rld_valid === 1'b0 && pt_ready === 1'b0,
                    {tag, " R10 stall holds"}, FW'({fifo_wr, rld_valid, pt_ready}), FW'(0));
                @(posedge clk);
                @(negedge clk);
            end
            fifo_full = 1'b0;
        end else begin
            fifo_full = (stall > 0);
        end
        #1;
        chk(pt_ready === 1'b0, {tag, " R2 ready low in decide"}, FW'(pt_ready), FW'(0));
        chk(fifo_wr === keep, {tag, keep ? " R4 write" : (dp ? " R5 no write" : " R6/R7 no write")},
            FW'(fifo_wr), FW'(keep));
        if (keep) begin
            chk(fifo_data === {m_sp[m_idx], p, m_birth[m_idx]}, {tag, " R4 data"},
                fifo_data, {m_sp[m_idx], p, m_birth[m_idx]});
        end
        chk(rld_valid === fin, {tag, fin ? " R5/R6 reload" : " R7 continue"},
            FW'(rld_valid), FW'(fin));
        chk(rld_elem === EW'(m_idx), {tag, " R9 element order"}, FW'(rld_elem), FW'(m_idx));
        if (fin) begin
            chk(rld_point === m_gen, {tag, " R8 new start"}, FW'(rld_point), FW'(m_gen));
            m_sp[m_idx]    = m_gen;
            m_birth[m_idx] = tmr;
            m_gen          = m_gen + 1'b1;
        end
        m_idx = (m_idx + 1) % N;
        @(posedge clk);
        @(negedge clk);
        fifo_full = 1'b0;
    endtask

    function automatic logic [PW-1:0] rnd_pt(input bit make_dp);
        logic [PW-1:0] p;
        p = {$urandom, $urandom};
        if (make_dp) p[PW-1 -: DB] = '0;
        else if (p[PW-1 -: DB] == '0) p[PW-1] = 1'b1;
        return p;
    endfunction

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < N; i++) begin
            m_sp[i]    = BASE + PW'(i);
            m_birth[i] = '0;
        end
        m_gen = BASE + PW'(N);
        m_idx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(pt_ready === 1'b1 && fifo_wr === 1'b0 && rld_valid === 1'b0, "R1 reset outputs",
            FW'({pt_ready, fifo_wr, rld_valid}), FW'(3'b100));
        @(negedge clk);
        // R1: first keep on each element shows its reset start and birth
        for (int i = 0; i < N; i++) run_eval(rnd_pt(1), KLO + 1 + i, 0, "R1");
        // R7: continue element 0, then later keep it: start and birth unchanged
        run_eval(rnd_pt(0), KHI - 1, 0, "R7 cont");
        for (int i = 1; i < N; i++) run_eval(rnd_pt(0), 3, 0, "R7 others");
        run_eval(rnd_pt(1), KLO + 2, 0, "R7 keep after cont");
        // window boundaries
        run_eval(rnd_pt(1), KLO, 0, "R5 k=kmin");
        run_eval(rnd_pt(1), KHI, 0, "R5 k=kmax");
        run_eval(rnd_pt(1), KHI - 1, 0, "R4 k=kmax-1");
        run_eval(rnd_pt(0), KHI, 0, "R6 long");
        run_eval(64'h07FF_FFFF_FFFF_FFFF, KLO + 1, 0, "R3 dp edge");
        run_eval(64'h0800_0000_0000_0000, KLO + 1, 0, "R3 not dp edge");
        // R10 backpressure on keep, and no blocking on discard or continue
        run_eval(rnd_pt(1), KLO + 5, 3, "R10 keep stalled");
        run_eval(rnd_pt(1), 1, 2, "R10 drop while full");
        run_eval(rnd_pt(0), 2, 2, "R10 cont while full");
        // constrained random mix
        for (int n = 0; n < 160; n++) begin
            int k;
            k = $urandom_range(0, KHI + 4);
            run_eval(rnd_pt($urandom_range(0, 1) == 1), k,
                     ($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0, "RND");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(10 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule